// File: doc/BRIEF.md
# Two-Level Memory Access Arbiter

This block decides which requester owns the next main-memory access cycle. Two groups of I/O control request lines and a single processor request line compete for it. Inside a group, one line is picked by a reprogrammable rank order. Between the two groups, a contested decision goes to the group that was not served last. The processor is served only when no group line is asking.

A grant is held until the memory side pulses `cycle_done`. After that pulse the arbiter spends one idle cycle and then makes the next decision. Each group line also carries a flag that says whether its data should pass through the code translator. The flag of the winning line is captured at decision time and forwarded as `gnt_xlat`.

A small state machine drives the block. Its states are:
- ST_IDLE: the decision state.
- ST_GRP0, ST_GRP1 and ST_CPU: the three holding states.

Its transitions are:
- ST_IDLE to ST_GRP0 or ST_GRP1, when any group line requests.
- ST_IDLE to ST_CPU, when only the processor requests.
- ST_IDLE to ST_IDLE, when nothing requests.
- A holding state back to ST_IDLE, on `cycle_done`.
- A holding state to itself, otherwise.

Top module: `mem_access_arbiter`

## Requirements
- R1: After reset, no grant is asserted and each group's rank order is the identity, so rank k holds line k. In the first contested decision, group 0 wins.
- R2: Within a group, the line granted is the requesting line that sits at the lowest-numbered rank. Rank 0 is the highest standing.
- R3: When `cfg_we` is high for one cycle, the rank order of the group named by `cfg_grp` is replaced. Field k of `cfg_order` (bits k*IDX_W and up, IDX_W bits wide) gives the line number at rank k. The other group's order is left unchanged.
- R4: When both groups request in the same decision cycle, the group that did not receive the previous group grant wins.
- R5: When only one group requests, that group wins whatever the history. The last-served record changes only on a group grant. A processor grant leaves it unchanged.
- R6: The processor is granted if and only if no line of either group requests in the decision cycle and `cpu_req` is high.
- R7: At most one grant line across `g0_gnt`, `g1_gnt` and `cpu_gnt` is high at any time.
- R8: A grant becomes visible in the cycle after the decision. It then holds unchanged, whatever the requests do, until the cycle in which `cycle_done` is high. All grants are low in the next cycle, and a new decision follows one cycle later.
- R9: `gnt_xlat` equals the translator flag of the granted line, sampled in the decision cycle. It is held for the whole grant and is 0 during a processor grant.
- R10: A `cycle_done` pulse while no grant is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| g0_req | input | NUM_LINES | Group 0 request lines |
| g0_xlat | input | NUM_LINES | Group 0 translator flags, one per line |
| g1_req | input | NUM_LINES | Group 1 request lines |
| g1_xlat | input | NUM_LINES | Group 1 translator flags, one per line |
| cpu_req | input | 1 | Processor request |
| cfg_we | input | 1 | Rank order write strobe |
| cfg_grp | input | 1 | Group selected by the rank order write |
| cfg_order | input | NUM_LINES*IDX_W | New rank order, one line number per rank |
| cycle_done | input | 1 | The memory cycle of the current grant has finished |
| g0_gnt | output | NUM_LINES | One-hot grant to group 0 lines |
| g1_gnt | output | NUM_LINES | One-hot grant to group 1 lines |
| cpu_gnt | output | 1 | Grant to the processor |
| gnt_xlat | output | 1 | Translator flag of the active grant |

## Verification
The bench builds the block with the default of ten lines per group. With that width the line index reaches 9, and the 4-bit rank fields carry their full range of used codes. Random rank permutations written into both groups let any line appear at any rank, so the top and bottom of the order are both reached. Sparse random request patterns put both groups, a single group and the processor alone into the decision cycle many times, which exercises the alternation record both with and without interleaved processor grants.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GRP0,
        ST_GRP1,
        ST_CPU
    } arb_state_t;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int NUM_LINES = 10,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [NUM_LINES*IDX_W-1:0] new_order,
    input  logic [NUM_LINES-1:0]       req,
    input  logic [NUM_LINES-1:0]       xlat,
    output logic                       any,
    output logic [IDX_W-1:0]           pick_idx,
    output logic                       pick_xlat
);
    logic [IDX_W-1:0] order_q [NUM_LINES];

    // rank register: identity after reset, replaced whole on a load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_LINES; k++)
                order_q[k] <= IDX_W'(k);
        end else if (load) begin
            for (int k = 0; k < NUM_LINES; k++)
                order_q[k] <= new_order[k*IDX_W +: IDX_W];
        end
    end

    // scan from the lowest rank up so rank 0 has the final say
    always_comb begin
        any      = 1'b0;
        pick_idx = '0;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (int'(order_q[k]) < NUM_LINES) begin
                if (req[order_q[k]]) begin
                    any      = 1'b1;
                    pick_idx = order_q[k];
                end
            end
        end
    end

    always_comb begin
        pick_xlat = 1'b0;
        for (int i = 0; i < NUM_LINES; i++)
            if (pick_idx == IDX_W'(i))
                pick_xlat = xlat[i];
    end
endmodule

// File: rtl/turn_keeper.sv
module turn_keeper (
    input  logic clk,
    input  logic rst_n,
    input  logic any0,
    input  logic any1,
    input  logic take,
    output logic win_grp
);
    logic last_q;

    // contested: the group not served last; otherwise whichever asks
    always_comb begin
        if (any0 && any1)
            win_grp = ~last_q;
        else
            win_grp = any1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_q <= 1'b1;
        else if (take)
            last_q <= win_grp;
    end
endmodule

// File: rtl/grant_fsm.sv
module grant_fsm
    import arb_pkg::*;
#(
    parameter int NUM_LINES = 10,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any0,
    input  logic             any1,
    input  logic             win_grp,
    input  logic             cpu_req,
    input  logic             done,
    input  logic [IDX_W-1:0] idx0,
    input  logic [IDX_W-1:0] idx1,
    input  logic             x0,
    input  logic             x1,
    output logic             take,
    output logic             grp0_act,
    output logic             grp1_act,
    output logic             cpu_act,
    output logic [IDX_W-1:0] line_q,
    output logic             xlat_q
);
    arb_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any0 || any1)
                    state_d = win_grp ? ST_GRP1 : ST_GRP0;
                else if (cpu_req)
                    state_d = ST_CPU;
            end
            ST_GRP0, ST_GRP1, ST_CPU: begin
                if (done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign take = (state_q == ST_IDLE) && (any0 || any1);

    // winner's line and flag are captured at the decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            xlat_q <= 1'b0;
        end else if (take) begin
            line_q <= win_grp ? idx1 : idx0;
            xlat_q <= win_grp ? x1 : x0;
        end
    end

    always_comb begin
        grp0_act = 1'b0;
        grp1_act = 1'b0;
        cpu_act  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GRP0: grp0_act = 1'b1;
            ST_GRP1: grp1_act = 1'b1;
            ST_CPU:  cpu_act  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mem_access_arbiter.sv
module mem_access_arbiter #(
    parameter int NUM_LINES = 10,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LINES-1:0]       g0_req,
    input  logic [NUM_LINES-1:0]       g0_xlat,
    input  logic [NUM_LINES-1:0]       g1_req,
    input  logic [NUM_LINES-1:0]       g1_xlat,
    input  logic                       cpu_req,
    input  logic                       cfg_we,
    input  logic                       cfg_grp,
    input  logic [NUM_LINES*IDX_W-1:0] cfg_order,
    input  logic                       cycle_done,
    output logic [NUM_LINES-1:0]       g0_gnt,
    output logic [NUM_LINES-1:0]       g1_gnt,
    output logic                       cpu_gnt,
    output logic                       gnt_xlat
);
    logic [NUM_LINES-1:0] req_a  [2];
    logic [NUM_LINES-1:0] xlat_a [2];
    logic                 any_a  [2];
    logic [IDX_W-1:0]     idx_a  [2];
    logic                 px_a   [2];

    assign req_a[0]  = g0_req;
    assign req_a[1]  = g1_req;
    assign xlat_a[0] = g0_xlat;
    assign xlat_a[1] = g1_xlat;

    for (genvar g = 0; g < 2; g++) begin : g_grp
        prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (cfg_we && (cfg_grp == g[0])),
            .new_order (cfg_order),
            .req       (req_a[g]),
            .xlat      (xlat_a[g]),
            .any       (any_a[g]),
            .pick_idx  (idx_a[g]),
            .pick_xlat (px_a[g])
        );
    end

    logic             win_grp, take;
    logic             grp0_act, grp1_act, cpu_act;
    logic [IDX_W-1:0] line_q;
    logic             xlat_q;

    turn_keeper u_turn (
        .clk     (clk),
        .rst_n   (rst_n),
        .any0    (any_a[0]),
        .any1    (any_a[1]),
        .take    (take),
        .win_grp (win_grp)
    );

    grant_fsm #(.NUM_LINES(NUM_LINES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any0     (any_a[0]),
        .any1     (any_a[1]),
        .win_grp  (win_grp),
        .cpu_req  (cpu_req),
        .done     (cycle_done),
        .idx0     (idx_a[0]),
        .idx1     (idx_a[1]),
        .x0       (px_a[0]),
        .x1       (px_a[1]),
        .take     (take),
        .grp0_act (grp0_act),
        .grp1_act (grp1_act),
        .cpu_act  (cpu_act),
        .line_q   (line_q),
        .xlat_q   (xlat_q)
    );

    always_comb begin
        g0_gnt = '0;
        g1_gnt = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            g0_gnt[i] = grp0_act && (line_q == IDX_W'(i));
            g1_gnt[i] = grp1_act && (line_q == IDX_W'(i));
        end
    end

    assign cpu_gnt  = cpu_act;
    assign gnt_xlat = xlat_q && (grp0_act || grp1_act);
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int NUM_LINES = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] g0_req,
    input logic [NUM_LINES-1:0] g1_req,
    input logic                 cycle_done,
    input logic [NUM_LINES-1:0] g0_gnt,
    input logic [NUM_LINES-1:0] g1_gnt,
    input logic                 cpu_gnt,
    input logic                 gnt_xlat
);
    logic any_gnt;
    assign any_gnt = (|g0_gnt) || (|g1_gnt) || cpu_gnt;

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({g0_gnt, g1_gnt, cpu_gnt}) <= 1);

    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_gnt && !cycle_done |=> $stable({g0_gnt, g1_gnt, cpu_gnt, gnt_xlat}));

    // R8
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_gnt && cycle_done |=> !any_gnt);

    // R6
    cpu_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_gnt) |-> ($past(g0_req) == '0) && ($past(g1_req) == '0));

    // R2
    g0_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|g0_gnt) |-> |(g0_gnt & $past(g0_req)));

    // R2
    g1_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|g1_gnt) |-> |(g1_gnt & $past(g1_req)));

    // R9
    cpu_noxlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |-> !gnt_xlat);
endmodule

bind mem_access_arbiter arb_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .g0_req     (g0_req),
    .g1_req     (g1_req),
    .cycle_done (cycle_done),
    .g0_gnt     (g0_gnt),
    .g1_gnt     (g1_gnt),
    .cpu_gnt    (cpu_gnt),
    .gnt_xlat   (gnt_xlat)
);

// File: tb/sim_mem_access_arbiter.sv
`timescale 1ns/1ps
module sim_mem_access_arbiter;
    localparam int N  = 10;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  g0_req = '0, g0_xlat = '0, g1_req = '0, g1_xlat = '0;
    logic          cpu_req = 1'b0, cfg_we = 1'b0, cfg_grp = 1'b0, cycle_done = 1'b0;
    logic [N*IW-1:0] cfg_order = '0;
    logic [N-1:0]  g0_gnt, g1_gnt;
    logic          cpu_gnt, gnt_xlat;

    int total = 0, fails = 0;
    int ord [2][N];
    bit last_grp = 1'b1;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mem_access_arbiter #(.NUM_LINES(N)) u0 (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] gvec();
        return {11'b0, cpu_gnt, g1_gnt, g0_gnt};
    endfunction

    function automatic int pick(int g, logic [N-1:0] r);
        for (int k = 0; k < N; k++)
            if (r[ord[g][k]]) return ord[g][k];
        return -1;
    endfunction

    task automatic write_order(bit g);
        logic [N*IW-1:0] v;
        for (int i = N - 1; i > 0; i--) begin
            int j, t;
            j = int'($urandom % (i + 1));
            t = ord[g][i]; ord[g][i] = ord[g][j]; ord[g][j] = t;
        end
        for (int k = 0; k < N; k++) v[k*IW +: IW] = IW'(ord[g][k]);
        g0_req = '0; g1_req = '0; cpu_req = 1'b0;
        cfg_we = 1'b1; cfg_grp = g; cfg_order = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // called at a negedge with the arbiter idle; returns at a negedge, idle
    task automatic trial(logic [N-1:0] r0, logic [N-1:0] r1, bit rc,
                         logic [N-1:0] x0, logic [N-1:0] x1, string tag);
        logic [31:0] ev;
        bit ex, g;
        int idx;
        g0_req = r0; g1_req = r1; cpu_req = rc; g0_xlat = x0; g1_xlat = x1;
        ev = '0; ex = 1'b0;
        if (r0 != '0 || r1 != '0) begin
            g = (r0 != '0 && r1 != '0) ? !last_grp : (r1 != '0);
            idx = pick(int'(g), g ? r1 : r0);
            ev = 32'd1 << (idx + (g ? N : 0));
            ex = g ? x1[idx] : x0[idx];
            last_grp = g;
        end else if (rc) begin
            ev = 32'd1 << (2 * N);
        end
        @(negedge clk);
        chk({tag, " grant"}, gvec(), ev);
        chk("R9 xlat", {31'b0, gnt_xlat}, {31'b0, ex});
        if (ev != '0) begin
            g0_req = N'($urandom); g1_req = N'($urandom); cpu_req = 1'($urandom);
            g0_xlat = N'($urandom); g1_xlat = N'($urandom);
            @(negedge clk);
            chk("R8 hold", gvec(), ev);
            chk("R9 hold", {31'b0, gnt_xlat}, {31'b0, ex});
            cycle_done = 1'b1;
            @(negedge clk);
            cycle_done = 1'b0;
            chk("R8 release", gvec(), 32'd0);
        end
    endtask

    function automatic logic [N-1:0] rnd_req();
        if ($urandom % 3 == 0) return '0;
        return N'($urandom) & N'($urandom);
    endfunction

    initial begin
        void'($urandom(32'h5eed_2024));
        for (int g = 0; g < 2; g++)
            for (int k = 0; k < N; k++) ord[g][k] = k;
        repeat (3) @(negedge clk);
        chk("R1 reset grants", gvec(), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", gvec(), 32'd0);
        // R1: identity order and group 0 first
        trial(10'b1010000000, 10'b0000000100, 1'b1, 10'h200, 10'h0, "R1");
        // R4: next contest to group 1
        trial(10'b0000000001, 10'b1000000000, 1'b0, 10'h0, 10'h200, "R4");
        // R5: a processor grant leaves the record alone
        trial('0, '0, 1'b1, '0, '0, "R6");
        trial(10'b0000010000, 10'b0000010000, 1'b0, 10'h010, 10'h0, "R5");
        trial('0, 10'b0000000010, 1'b0, '0, '0, "R5 single");
        trial('0, '0, 1'b0, '0, '0, "R6 none");
        // R10: done while idle
        cycle_done = 1'b1;
        @(negedge clk);
        cycle_done = 1'b0;
        chk("R10 idle done", gvec(), 32'd0);
        trial(10'b0000000011, '0, 1'b1, 10'h3, '0, "R10 then grant");
        // R3: reprogram group 0; group 1 must keep identity
        write_order(1'b0);
        trial(10'h3FF, '0, 1'b0, 10'h155, '0, "R3 new order");
        trial('0, 10'b0000001100, 1'b0, '0, 10'h004, "R3 other group");
        write_order(1'b1);
        for (int t = 0; t < 400; t++) begin
            logic [N-1:0] a, b;
            if (t % 50 == 49) write_order(1'($urandom));
            a = rnd_req(); b = rnd_req();
            trial(a, b, 1'($urandom), N'($urandom), N'($urandom),
                  (a != '0 && b != '0) ? "R4 rnd" : (a != '0 || b != '0) ? "R2 rnd" : "R6 rnd");
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule